// File: doc/BRIEF.md
# Shared-Memory Bus Controller

This block sits between a processor's memory port and a shared SRAM bus that two masters reach through a central arbiter. The processor raises a read or write request together with a byte address and, for writes, the data. The controller then raises an active-low bus request and waits for the arbiter's active-low grant. Once granted, it issues a single active-low strobe, with the active-low write select on writes. On reads it latches the returned word and hands it to the processor.

For the whole exchange the controller holds the processor's wait line high. The memory is word-addressed: the two lowest byte-address bits never reach the memory address bus. Address and write data are driven from registers loaded when the request is accepted. If the arbiter takes the grant away before the strobe goes out, the controller goes back to requesting and the processor stays stalled. Reset is synchronous and active-low.

Top module: `shmem_bus_ctrl`

## Requirements
- R1: While reset is low at a clock edge, the controller returns to idle: after that edge mem_req_n, mem_stb_n and mem_we_n read 1 and cpu_wait reads 0 with no CPU request present.
- R2: In the idle state, cpu_wait goes to 1 in the same cycle that cpu_rd or cpu_wr is first seen high, with no clock edge in between.
- R3: mem_req_n goes low in the cycle after a request is accepted and stays low until the completion cycle ends; in the following cycle it reads 1 again.
- R4: mem_stb_n is low for exactly the one cycle that follows a cycle where mem_gnt_n was sampled low while requesting, and only while mem_gnt_n is still low; it is never low while mem_req_n is high.
- R5: mem_we_n is low together with mem_stb_n on write accesses and stays high on read accesses. cpu_wr takes priority if both requests are high.
- R6: mem_addr carries cpu_addr bits [25:2] (the byte address divided by 4), captured when the request is accepted. It is held constant while mem_req_n is low.
- R7: mem_wdata carries the cpu_wdata value present when a write is accepted.
- R8: mem_rdata is sampled in the strobe cycle of a read. The captured word appears on cpu_rdata in the next cycle, which is the single completion cycle where cpu_wait is 0 and mem_req_n is still low.
- R9: If mem_gnt_n is high in the cycle the strobe would go out, no strobe is issued. The controller returns to requesting with mem_req_n low and cpu_wait high.
- R10: cpu_wait stays 1 for every cycle spent waiting for a grant, however long that is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_addr | input | 26 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_wait | output | 1 | Stall to the CPU while the access is in flight |
| cpu_rdata | output | 32 | Read word returned to the CPU |
| mem_req_n | output | 1 | Bus request to the arbiter, active low |
| mem_stb_n | output | 1 | Memory strobe, active low |
| mem_we_n | output | 1 | Write select, active low |
| mem_gnt_n | input | 1 | Bus grant from the arbiter, active low |
| mem_addr | output | 24 | Registered word address |
| mem_wdata | output | 32 | Registered write data |
| mem_rdata | input | 32 | Read data from the memory |

## Verification
cpu_wait answers a new request combinationally, so it is checked in the same cycle the request is driven. mem_req_n, mem_addr and mem_wdata are due one edge after acceptance. The strobe is due one edge after grant is sampled, and completion with its read data one edge after the strobe. mem_req_n goes high again one edge after completion. Grant delays of several lengths and a withdrawn grant shift these points by a known number of cycles. The bench drives every input on the falling edge and samples one nanosecond later, so each check reads the state one known rising edge has produced.

// File: rtl/shmem_pkg.sv
// Shared types for the shared-memory bus controller.
// Assumes: four-state sequence, encoded in two bits.
package shmem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ACC  = 2'd2,
        ST_DONE = 2'd3
    } bus_state_t;

endpackage

// File: rtl/shmem_seq.sv
// Sequencer: walks idle -> request -> access -> done and decodes the
// active-low bus controls and the CPU stall from the state.
// Assumes: the grant input is already synchronous to clk.
module shmem_seq
    import shmem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_rd,
    input  logic cpu_wr,
    input  logic gnt_n,
    input  logic wr_q,
    output logic start,
    output logic capture,
    output logic req_n,
    output logic stb_n,
    output logic we_n,
    output logic stall
);

    bus_state_t st, st_nxt;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Next-state decode; a lost grant in access falls back to request.
    always_comb begin
        st_nxt = st;
        case (st)
            ST_IDLE: if (cpu_rd || cpu_wr) st_nxt = ST_REQ;
            ST_REQ:  if (!gnt_n)           st_nxt = ST_ACC;
            ST_ACC:  st_nxt = gnt_n ? ST_REQ : ST_DONE;
            ST_DONE: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Output decode: strobe only while the grant is still held.
    always_comb begin
        start   = (st == ST_IDLE) && (cpu_rd || cpu_wr);
        capture = (st == ST_ACC) && !gnt_n;
        req_n   = (st == ST_IDLE);
        stb_n   = !capture;
        we_n    = !(capture && wr_q);
        stall   = start || (st == ST_REQ) || (st == ST_ACC);
    end

endmodule

// File: rtl/shmem_hold_regs.sv
// Holding registers for the word address, write data and access type,
// loaded once when a request is accepted.
// Assumes: load is a single-cycle pulse issued only from idle.
module shmem_hold_regs #(
    parameter int MEM_AW = 24,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              is_wr,
    input  logic [MEM_AW-1:0] word_addr,
    input  logic [DW-1:0]     wdata,
    output logic [MEM_AW-1:0] addr_q,
    output logic [DW-1:0]     wdata_q,
    output logic              wr_q
);

    // Capture the request fields; they stay fixed for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (load) begin
            addr_q  <= word_addr;
            wdata_q <= wdata;
            wr_q    <= is_wr;
        end
    end

endmodule

// File: rtl/shmem_rd_capture.sv
// Read-data latch: samples the memory read bus in the strobe cycle of a read.
// Assumes: memory data is valid while the strobe is low.
module shmem_rd_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          wr_q,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rdata_q
);

    // Latch the word only on a granted read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (capture && !wr_q) rdata_q <= mem_rdata;
    end

endmodule

// File: rtl/shmem_bus_ctrl.sv
// Top of the shared-memory bus controller: bridges a stalled CPU memory port
// to a request/grant arbitrated, word-addressed SRAM bus.
// Assumes: byte-lane alignment is done elsewhere; bits [1:0] of the byte
// address are dropped; a write wins if both requests are high.
module shmem_bus_ctrl #(
    parameter int MEM_AW = 24,
    parameter int DW     = 32,
    localparam int CPU_AW = MEM_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic              cpu_wait,
    output logic [DW-1:0]     cpu_rdata,
    output logic              mem_req_n,
    output logic              mem_stb_n,
    output logic              mem_we_n,
    input  logic              mem_gnt_n,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);

    logic start, capture, wr_q;
    logic unused_byte_lane;

    // Byte offset is not used on a word-addressed bus.
    assign unused_byte_lane = ^cpu_addr[1:0];

    shmem_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_rd  (cpu_rd),
        .cpu_wr  (cpu_wr),
        .gnt_n   (mem_gnt_n),
        .wr_q    (wr_q),
        .start   (start),
        .capture (capture),
        .req_n   (mem_req_n),
        .stb_n   (mem_stb_n),
        .we_n    (mem_we_n),
        .stall   (cpu_wait)
    );

    shmem_hold_regs #(.MEM_AW(MEM_AW), .DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .is_wr     (cpu_wr),
        .word_addr (cpu_addr[CPU_AW-1:2]),
        .wdata     (cpu_wdata),
        .addr_q    (mem_addr),
        .wdata_q   (mem_wdata),
        .wr_q      (wr_q)
    );

    shmem_rd_capture #(.DW(DW)) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .wr_q      (wr_q),
        .mem_rdata (mem_rdata),
        .rdata_q   (cpu_rdata)
    );

endmodule

// File: rtl/shmem_bus_ctrl_chk.sv
// Protocol checker for shmem_bus_ctrl, attached by bind below.
// Assumes: reset is held low for at least one clock edge at start-up.
module shmem_bus_ctrl_chk #(
    parameter int MEM_AW = 24,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cpu_wait,
    input logic [DW-1:0]     cpu_rdata,
    input logic              mem_req_n,
    input logic              mem_stb_n,
    input logic              mem_we_n,
    input logic              mem_gnt_n,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [DW-1:0]     mem_rdata
);

    // R2: an idle controller stalls the CPU at once.
    a_r2_wait_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_n && (cpu_rd || cpu_wr)) |-> cpu_wait);

    // R4: strobe only while requesting and granted.
    a_r4_stb_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_stb_n |-> (!mem_req_n && !mem_gnt_n));

    // R5: write select never appears without the strobe.
    a_r5_we_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_stb_n);

    // R8: a granted strobe completes in the next cycle.
    a_r8_done_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_stb_n |=> (!cpu_wait && !mem_req_n && mem_stb_n));

    // R8: read data is the word seen during the strobe.
    a_r8_rdata_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_stb_n && mem_we_n) |=> (cpu_rdata == $past(mem_rdata)));

    // R3: the request is dropped right after the completion cycle.
    a_r3_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_n && !cpu_wait) |=> mem_req_n);

    // R6: the word address does not move during an access.
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_n && !$past(mem_req_n)) |-> $stable(mem_addr));

    // R9: a lost grant in the access cycle keeps the CPU stalled.
    a_r9_lost_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_n && mem_stb_n && cpu_wait && mem_gnt_n) |=> (!mem_req_n && cpu_wait));

endmodule

bind shmem_bus_ctrl shmem_bus_ctrl_chk #(.MEM_AW(MEM_AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wait  (cpu_wait),
    .cpu_rdata (cpu_rdata),
    .mem_req_n (mem_req_n),
    .mem_stb_n (mem_stb_n),
    .mem_we_n  (mem_we_n),
    .mem_gnt_n (mem_gnt_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata)
);

// File: tb/shmem_bus_ctrl_test.sv
// Directed bench for shmem_bus_ctrl: one task per scenario, inputs driven on
// the falling edge and outputs sampled 1 ns later.
module shmem_bus_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [25:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_wait;
    logic [31:0] cpu_rdata;
    logic        mem_req_n, mem_stb_n, mem_we_n;
    logic        mem_gnt_n = 1'b1;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // Bench memory: read word is a fixed function of the word address.
    function automatic logic [31:0] mem_word(input logic [23:0] a);
        return {a[7:0], a} ^ 32'hC3C3_0000;
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    shmem_bus_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_wait  (cpu_wait),
        .cpu_rdata (cpu_rdata),
        .mem_req_n (mem_req_n),
        .mem_stb_n (mem_stb_n),
        .mem_we_n  (mem_we_n),
        .mem_gnt_n (mem_gnt_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // R1: reset values of all controls.
    task automatic t_reset();
        rst_n = 1'b0;
        cpu_rd = 0; cpu_wr = 0; mem_gnt_n = 1;
        step(); step();
        rst_n = 1'b1;
        #0;
        chk(mem_req_n == 1'b1, "R1", "req_n", 32'(mem_req_n), 32'd1);
        chk(mem_stb_n == 1'b1, "R1", "stb_n", 32'(mem_stb_n), 32'd1);
        chk(mem_we_n  == 1'b1, "R1", "we_n",  32'(mem_we_n),  32'd1);
        chk(cpu_wait  == 1'b0, "R1", "wait",  32'(cpu_wait),  32'd0);
    endtask

    // One access: grant after 'delay' cycles, optionally lost once in access.
    task automatic t_access(input bit wr, input bit both, input logic [25:0] a,
                            input logic [31:0] d, input int delay, input bit lose);
        logic [23:0] wa = a[25:2];
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rd = !wr || both; cpu_wr = wr;
        mem_gnt_n = 1'b1;
        #1;
        chk(cpu_wait == 1'b1, "R2", "wait same cycle", 32'(cpu_wait), 32'd1);
        chk(mem_req_n == 1'b1, "R3", "req_n before accept", 32'(mem_req_n), 32'd1);
        step();
        chk(mem_req_n == 1'b0, "R3", "req_n after accept", 32'(mem_req_n), 32'd0);
        chk(mem_addr == wa, "R6", "word address", 32'(mem_addr), 32'(wa));
        if (wr) chk(mem_wdata == d, "R7", "write data", mem_wdata, d);
        for (int i = 0; i < delay; i++) begin
            step();
            chk(cpu_wait == 1'b1, "R10", "wait during grant delay", 32'(cpu_wait), 32'd1);
            chk(mem_stb_n == 1'b1, "R10", "no strobe without grant", 32'(mem_stb_n), 32'd1);
        end
        mem_gnt_n = 1'b0;
        step();
        if (lose) begin
            mem_gnt_n = 1'b1;
            #1;
            chk(mem_stb_n == 1'b1, "R9", "no strobe on lost grant", 32'(mem_stb_n), 32'd1);
            chk(cpu_wait == 1'b1, "R9", "wait on lost grant", 32'(cpu_wait), 32'd1);
            step();
            chk(mem_req_n == 1'b0, "R9", "req_n kept", 32'(mem_req_n), 32'd0);
            chk(cpu_wait == 1'b1, "R9", "wait kept", 32'(cpu_wait), 32'd1);
            chk(mem_stb_n == 1'b1, "R9", "still no strobe", 32'(mem_stb_n), 32'd1);
            mem_gnt_n = 1'b0;
            step();
        end
        chk(mem_stb_n == 1'b0, "R4", "strobe after grant", 32'(mem_stb_n), 32'd0);
        chk(mem_we_n == !wr, "R5", "write select", 32'(mem_we_n), 32'(!wr));
        chk(mem_addr == wa, "R6", "address held", 32'(mem_addr), 32'(wa));
        step();
        chk(cpu_wait == 1'b0, "R8", "wait low at completion", 32'(cpu_wait), 32'd0);
        chk(mem_req_n == 1'b0, "R3", "req_n through completion", 32'(mem_req_n), 32'd0);
        chk(mem_stb_n == 1'b1, "R4", "single strobe", 32'(mem_stb_n), 32'd1);
        if (!wr) chk(cpu_rdata == mem_word(wa), "R8", "read data", cpu_rdata, mem_word(wa));
        cpu_rd = 0; cpu_wr = 0; mem_gnt_n = 1'b1;
        step();
        chk(mem_req_n == 1'b1, "R3", "req_n released", 32'(mem_req_n), 32'd1);
        chk(cpu_wait == 1'b0, "R3", "idle no wait", 32'(cpu_wait), 32'd0);
    endtask

    initial begin
        t_reset();
        t_access(1'b0, 1'b0, 26'h000_0124, 32'h0, 0, 1'b0);
        t_access(1'b1, 1'b0, 26'h2AB_CDE8, 32'hDEAD_BEEF, 2, 1'b0);
        t_access(1'b0, 1'b0, 26'h3FF_FFFF, 32'h0, 3, 1'b1);
        t_access(1'b1, 1'b1, 26'h155_5556, 32'h1234_5678, 1, 1'b1);
        t_access(1'b0, 1'b0, 26'h001_0003, 32'h0, 5, 1'b0);
        t_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule